// File: doc/BRIEF.md
# Event Readout Formatter

The formatter sits between a hit source and a 16-bit word link. A readout strobe arrives together with a 4-bit event number. When the block is idle, the strobe starts an event: the number is captured, BUSY goes high, and hit words are taken from the upstream valid/ready source until the word flagged as last has been taken. Each hit is forwarded unchanged as one output word.

After the hit data, the block appends a two-word trailer. The first trailer word carries a fixed stream identifier and the captured event number. The second carries the number of data words in the event. If the total word count would be odd, a filler word is added after the trailer. The final word of the event is marked by a one-cycle end-of-record pulse. BUSY then drops so the next trigger can be accepted.

A strobe that arrives while an event is still in progress does not start a new event. It raises a sticky overrun flag. With no stalls on either side, the block moves one word per clock, so an event of about 150 hits stays well within a 30 µs dead-time budget.

Top module: `evfmt_ctrl`

## Requirements
- R1: After reset, busy_o, overrun_o, word_valid_o, eor_o and hit_ready_o are all 0.
- R2: A strobe sampled while busy_o is 0 captures evt_num_i and raises busy_o from the next cycle. busy_o stays high until the cycle after the end-of-record pulse.
- R3: Hit words are forwarded in arrival order with unchanged values. hit_ready_o is high only while busy_o is high and the data phase of the event is active.
- R4: Right after the last data word, the first trailer word is emitted: the stream identifier (default 0x5C) in bits [15:8], zeros in bits [7:4], and the captured event number in bits [3:0].
- R5: The second trailer word holds the number of data words in the event. Trailer and filler words are not counted.
- R6: When the data word count is odd, one filler word of value 0xFFFF follows the second trailer word. When the count is even, no filler word is sent.
- R7: eor_o is high for exactly one cycle, the cycle in which the final word of the event is accepted (word_valid_o and word_ready_i both high). busy_o is 0 in the following cycle.
- R8: A strobe sampled while busy_o is 1 is ignored: no event starts and the current event number is unchanged. It sets overrun_o, which stays set until reset.
- R9: While word_valid_o is high and word_ready_i is low, word_valid_o stays high and word_data_o stays unchanged in the next cycle.
- R10: With hits presented back to back and word_ready_i held high, an event of N hits keeps busy_o high for N+3 cycles when N is even and N+4 cycles when N is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe_i | input | 1 | Readout trigger strobe |
| evt_num_i | input | 4 | Event number, valid with the strobe |
| hit_valid_i | input | 1 | Hit source has a word |
| hit_data_i | input | 16 | Hit word |
| hit_last_i | input | 1 | Marks the final hit word of the event |
| hit_ready_o | output | 1 | Block takes the hit word this cycle |
| word_valid_o | output | 1 | Output word is valid |
| word_data_o | output | 16 | Output word |
| word_ready_i | input | 1 | Downstream accepts the output word |
| eor_o | output | 1 | End-of-record pulse on the final word handshake |
| busy_o | output | 1 | Event readout in progress |
| overrun_o | output | 1 | Sticky flag: strobe arrived while busy |

## Verification
A wrong phase in the sequencer shows up at the next output handshake: a trailer word appears in place of data, a filler word is missing or extra, or eor_o fires on the wrong word. A corrupted data counter shows up in the second trailer word, and also in the filler decision, within one or two words after the last hit. A busy or overrun fault shows up one cycle after the strobe or after the end-of-record handshake. The bench compares busy, overrun, end-of-record and every accepted word against its own model on each clock, so any of these faults is caught within the cycle it first reaches the ports.

// File: rtl/evfmt_pkg.sv
package evfmt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_DATA  = 3'd1,
    PH_TRL0  = 3'd2,
    PH_TRL1  = 3'd3,
    PH_PAD   = 3'd4,
    PH_DRAIN = 3'd5
  } evfmt_phase_e;

endpackage

// File: rtl/evfmt_trig_capture.sv
module evfmt_trig_capture #(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             release_i,
  output logic             start_o,
  output logic             busy_o,
  output logic [EVT_W-1:0] evt_o,
  output logic             overrun_o
);

  logic             busy_q;
  logic             ovr_q;
  logic [EVT_W-1:0] evt_q;

  assign start_o   = strobe_i && !busy_q;
  assign busy_o    = busy_q;
  assign evt_o     = evt_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ovr_q  <= 1'b0;
      evt_q  <= '0;
    end else begin
      if (start_o) begin
        busy_q <= 1'b1;
        evt_q  <= evt_i;
      end else if (release_i) begin
        busy_q <= 1'b0;
      end
      if (strobe_i && busy_q) ovr_q <= 1'b1;
    end
  end

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && busy_q) |=> overrun_o);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

  // R8
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !release_i) |=> (busy_o && $stable(evt_o)));

endmodule

// File: rtl/evfmt_word_count.sv
module evfmt_word_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/evfmt_out_stage.sv
module evfmt_out_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              last_i,
  input  logic              ready_i,
  output logic              free_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              eor_o
);

  logic              vld_q;
  logic              last_q;
  logic [DATA_W-1:0] dat_q;

  assign free_o  = !vld_q || ready_i;
  assign valid_o = vld_q;
  assign data_o  = dat_q;
  assign eor_o   = vld_q && last_q && ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      dat_q  <= '0;
    end else if (load_i) begin
      vld_q  <= 1'b1;
      last_q <= last_i;
      dat_q  <= data_i;
    end else if (ready_i) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

  // R7
  eor_single_chk: assert property (@(posedge clk) disable iff (rst)
    eor_o |=> !eor_o);

endmodule

// File: rtl/evfmt_ctrl.sv
module evfmt_ctrl
  import evfmt_pkg::*;
#(
  parameter int              DATA_W    = 16,
  parameter int              EVT_W     = 4,
  parameter int              ID_W      = 8,
  parameter logic [ID_W-1:0] STREAM_ID = 8'h5C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe_i,
  input  logic [EVT_W-1:0]  evt_num_i,
  input  logic              hit_valid_i,
  input  logic [DATA_W-1:0] hit_data_i,
  input  logic              hit_last_i,
  output logic              hit_ready_o,
  output logic              word_valid_o,
  output logic [DATA_W-1:0] word_data_o,
  input  logic              word_ready_i,
  output logic              eor_o,
  output logic              busy_o,
  output logic              overrun_o
);

  localparam int              GAP_W    = DATA_W - ID_W - EVT_W;
  localparam logic [DATA_W-1:0] PAD_WORD = '1;

  evfmt_phase_e      ph_q, ph_d;
  logic              start;
  logic              free;
  logic              load;
  logic              load_last;
  logic [DATA_W-1:0] load_data;
  logic              cnt_inc;
  logic [DATA_W-1:0] data_cnt;
  logic [EVT_W-1:0]  evt_q;
  logic              eor;
  logic              busy;

  evfmt_trig_capture #(.EVT_W(EVT_W)) u_trig (
    .clk       (clk),
    .rst       (rst),
    .strobe_i  (rd_strobe_i),
    .evt_i     (evt_num_i),
    .release_i (eor),
    .start_o   (start),
    .busy_o    (busy),
    .evt_o     (evt_q),
    .overrun_o (overrun_o)
  );

  evfmt_word_count #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (start),
    .inc_i   (cnt_inc),
    .count_o (data_cnt)
  );

  evfmt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .data_i  (load_data),
    .last_i  (load_last),
    .ready_i (word_ready_i),
    .free_o  (free),
    .valid_o (word_valid_o),
    .data_o  (word_data_o),
    .eor_o   (eor)
  );

  always_comb begin
    ph_d        = ph_q;
    load        = 1'b0;
    load_last   = 1'b0;
    load_data   = '0;
    cnt_inc     = 1'b0;
    hit_ready_o = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) ph_d = PH_DATA;
      end
      PH_DATA: begin
        hit_ready_o = free;
        if (hit_valid_i && free) begin
          load      = 1'b1;
          load_data = hit_data_i;
          cnt_inc   = 1'b1;
          if (hit_last_i) ph_d = PH_TRL0;
        end
      end
      PH_TRL0: begin
        if (free) begin
          load      = 1'b1;
          load_data = {STREAM_ID, {GAP_W{1'b0}}, evt_q};
          ph_d      = PH_TRL1;
        end
      end
      PH_TRL1: begin
        if (free) begin
          load      = 1'b1;
          load_data = data_cnt;
          if (data_cnt[0]) begin
            ph_d = PH_PAD;
          end else begin
            load_last = 1'b1;
            ph_d      = PH_DRAIN;
          end
        end
      end
      PH_PAD: begin
        if (free) begin
          load      = 1'b1;
          load_data = PAD_WORD;
          load_last = 1'b1;
          ph_d      = PH_DRAIN;
        end
      end
      PH_DRAIN: begin
        if (eor) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_IDLE;
    else     ph_q <= ph_d;
  end

  assign eor_o  = eor;
  assign busy_o = busy;

  // R7
  eor_release_chk: assert property (@(posedge clk) disable iff (rst)
    eor_o |=> !busy_o);

  // R7
  eor_in_event_chk: assert property (@(posedge clk) disable iff (rst)
    eor_o |-> (busy_o && word_valid_o && word_ready_i));

  // R3
  ready_in_event_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ready_o |-> busy_o);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && !busy_o) |=> busy_o);

endmodule

// File: tb/evfmt_ctrl_tb_top.sv
module evfmt_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_strobe = 1'b0;
  logic [3:0]  evt_num = 4'h0;
  logic        hit_valid = 1'b0;
  logic [15:0] hit_data = 16'h0;
  logic        hit_last = 1'b0;
  logic        hit_ready;
  logic        word_valid;
  logic [15:0] word_data;
  logic        word_ready = 1'b1;
  logic        eor;
  logic        busy;
  logic        overrun;

  always #2.5 clk = ~clk;

  evfmt_ctrl dut_i (
    .clk          (clk),
    .rst          (rst),
    .rd_strobe_i  (rd_strobe),
    .evt_num_i    (evt_num),
    .hit_valid_i  (hit_valid),
    .hit_data_i   (hit_data),
    .hit_last_i   (hit_last),
    .hit_ready_o  (hit_ready),
    .word_valid_o (word_valid),
    .word_data_o  (word_data),
    .word_ready_i (word_ready),
    .eor_o        (eor),
    .busy_o       (busy),
    .overrun_o    (overrun)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Behavioural reference model, advanced once per clock
  logic [15:0] exp_q[$];
  bit          m_busy   = 1'b0;
  bit          m_ovr    = 1'b0;
  bit          m_tail   = 1'b0;
  logic [3:0]  m_evt    = 4'h0;
  int          m_cnt    = 0;
  bit          p_stall  = 1'b0;
  logic [15:0] p_data   = 16'h0;
  int          busy_cyc = 0;
  int          eor_seen = 0;
  int          rdy_mode = 0;

  always @(negedge clk) begin
    if (rst) begin
      exp_q.delete();
      m_busy = 0; m_ovr = 0; m_tail = 0; m_cnt = 0; p_stall = 0;
    end else begin
      bit out_fire, exp_eor, pre_busy;
      pre_busy = m_busy;
      out_fire = word_valid && word_ready;
      if (busy) busy_cyc++;
      check(busy == m_busy, "R2 busy", busy, m_busy);
      check(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
      check(!hit_ready || m_busy, "R3 ready outside event", hit_ready, 0);
      if (p_stall) begin
        check(word_valid, "R9 valid held", word_valid, 1);
        check(word_data == p_data, "R9 data held", word_data, p_data);
      end
      exp_eor = 1'b0;
      if (out_fire) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected word", word_data, 0);
        end else begin
          check(word_data == exp_q[0], "R3/R4/R5/R6 word", word_data, exp_q[0]);
          void'(exp_q.pop_front());
          exp_eor = m_tail && (exp_q.size() == 0);
        end
      end
      check(eor == exp_eor, "R7 eor", eor, exp_eor);
      if (eor) eor_seen++;
      p_stall = word_valid && !word_ready;
      p_data  = word_data;
      if (rd_strobe) begin
        if (!pre_busy) begin
          m_busy = 1; m_evt = evt_num; m_cnt = 0;
        end else begin
          m_ovr = 1;
        end
      end
      if (hit_valid && hit_ready) begin
        exp_q.push_back(hit_data);
        m_cnt++;
        if (hit_last) begin
          exp_q.push_back({8'h5C, 4'h0, m_evt});
          exp_q.push_back(16'(m_cnt));
          if (m_cnt % 2 == 1) exp_q.push_back(16'hFFFF);
          m_tail = 1;
        end
      end
      if (exp_eor) begin
        m_busy = 0; m_tail = 0;
      end
    end
  end

  // Downstream ready driver
  always @(posedge clk) begin
    #1;
    if (rdy_mode == 0) word_ready <= 1'b1;
    else               word_ready <= ($urandom % 4) != 0;
  end

  task automatic pulse_strobe(input logic [3:0] n);
    @(posedge clk); #1;
    rd_strobe = 1'b1; evt_num = n;
    @(posedge clk); #1;
    rd_strobe = 1'b0;
  endtask

  task automatic send_event(input logic [3:0] n, input int hits, input bit gaps);
    pulse_strobe(n);
    for (int i = 0; i < hits; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        hit_valid = 1'b0;
        @(posedge clk); #1;
      end
      hit_valid = 1'b1;
      hit_data  = 16'($urandom);
      hit_last  = (i == hits - 1);
      forever begin
        @(negedge clk);
        if (hit_ready) begin
          @(posedge clk); #1;
          break;
        end
      end
      hit_valid = 1'b0;
      hit_last  = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1 busy", busy, 0);
    check(!overrun, "R1 overrun", overrun, 0);
    check(!word_valid, "R1 valid", word_valid, 0);
    check(!eor, "R1 eor", eor, 0);
    check(!hit_ready, "R1 ready", hit_ready, 0);

    // R4 R5 even event, no stalls; R10 busy length N+3
    busy_cyc = 0;
    send_event(4'h3, 4, 0);
    check(busy_cyc == 7, "R10 busy cycles even", busy_cyc, 7);

    // R6 single hit, pad word; R10 odd length N+4
    busy_cyc = 0;
    send_event(4'hA, 1, 0);
    check(busy_cyc == 5, "R10 busy cycles odd", busy_cyc, 5);

    // R9 backpressure and hit gaps
    rdy_mode = 1;
    send_event(4'h7, 5, 1);
    send_event(4'h2, 6, 1);

    // R8 strobe during an active event
    fork
      send_event(4'h5, 8, 1);
      begin
        repeat (4) @(posedge clk);
        #1 rd_strobe = 1'b1; evt_num = 4'hF;
        @(posedge clk); #1 rd_strobe = 1'b0;
      end
    join
    check(overrun, "R8 overrun sticky", overrun, 1);
    repeat (4) @(negedge clk);
    check(!busy && !word_valid, "R8 no event started", busy, 0);

    // R10 dead-time budget: 150 hits
    rdy_mode = 0;
    repeat (2) @(posedge clk);
    busy_cyc = 0;
    send_event(4'h9, 150, 0);
    check(busy_cyc == 153, "R10 busy cycles 150 hits", busy_cyc, 153);

    // mixed random events
    rdy_mode = 1;
    for (int e = 0; e < 12; e++) send_event(4'(e), 1 + int'($urandom % 9), 1);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all words delivered", exp_q.size(), 0);
    check(eor_seen == 18, "R7 eor per event", eor_seen, 18);
    finish_run();
  end

endmodule